// File: doc/BRIEF.md
# Half-Port Pin Interrupt Channel

This block gathers up to 32 external pin requests into a single interrupt request line. The pins of the chip are organised in groups of eight (half ports). Each of the channel's 8-bit slots is fed by one half port, chosen by a selection field. Every selected pin goes through a synchronizer. It then passes through a detector that is either edge- or level-sensitive, with its own active polarity. A hit sets a per-pin latch, and a per-pin mask decides which latches reach the request output.

Software sees one 32-bit register space. It holds the slot selections, the trigger mode and polarity vectors, the mask and latch registers, and the synchronized pin levels. The mask and the latch each have two addresses. At the set address, each written 1 sets a bit. At the clear address, each written 1 clears a bit. Both addresses read back the current value. Latches fill in whether or not a pin is masked, so a handler can poll pins it has not enabled.

Top module: `pin_irq_chan`

## Requirements
- R1: After reset all registers read 0 and `irq_o` is low.
- R2: The selection register (word 0) holds the half-port number for slot k in bits [8k+2:8k]. Channel bit 8k+j carries pin 8*sel_k+j.
- R3: The pin-state register (word 7) returns the routed pin levels after the synchronizer. Polarity and mask do not change it.
- R4: In edge mode (bit set in word 1), a pin's latch sets on a transition into the active level. The active level is high when its word-2 polarity bit is 0 and low when it is 1.
- R5: In level mode (word 1 bit 0), the latch is set again on every cycle the active level is present. A clear written while the level is active has no effect.
- R6: Latches capture hits whether or not the pin is masked. They read back at word 5 and word 6.
- R7: Each 1 written to word 3 sets that mask bit, and each 1 written to word 4 clears it. Word 5 and word 6 do the same for the latches. Bits written as 0 are unchanged, and both words of a pair read back the current value.
- R8: `irq_o` is high exactly when some latch bit and its mask bit are both 1.
- R9: A pin change shows in the pin-state register after the second rising edge and in the latch after the third rising edge.
- R10: Words 8 to 15 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_HP*8 | Raw asynchronous pin levels, half port h on bits [8h+7:8h] |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| irq_o | output | 1 | Combined masked interrupt request |

## Verification
The hardest case to reach is a level-mode latch clear that is written while the pin still holds its active level. The clear must lose to the re-set in the same cycle. The bench drives a pin to its active level and waits out the synchronizer latency. It then writes the clear and reads the latch back, and only after it releases the pin and clears again does the latch drop. A cycle-accurate behavioural model, compared every clock, also covers polarity flips on steady pins and slot reselection, since either could fake an edge.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int REG_AW = 4;
  localparam int REG_DW = 32;

  typedef enum logic [REG_AW-1:0] {
    ADR_ROUTE    = 4'd0,
    ADR_TRIG     = 4'd1,
    ADR_POL      = 4'd2,
    ADR_MASK_SET = 4'd3,
    ADR_MASK_CLR = 4'd4,
    ADR_LAT_SET  = 4'd5,
    ADR_LAT_CLR  = 4'd6,
    ADR_PIN      = 4'd7
  } reg_adr_e;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[s] <= '0;
      else if (s == 0) st_q[s] <= d_i;
      else st_q[s] <= st_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/pin_irq_route.sv
module pin_irq_route #(
  parameter int NUM_HP = 8,
  parameter int SLOTS  = 4,
  parameter int SEL_W  = 3
) (
  input  logic [NUM_HP*8-1:0]    pins_i,
  input  logic [SLOTS*SEL_W-1:0] sel_i,
  output logic [SLOTS*8-1:0]     ch_o
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    always_comb begin
      ch_o[k*8 +: 8] = '0;
      for (int h = 0; h < NUM_HP; h++) begin
        if (sel_i[k*SEL_W +: SEL_W] == SEL_W'(h)) ch_o[k*8 +: 8] = pins_i[h*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] edge_mode_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q, act, act_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  // polarity applied to both samples so a polarity change on a steady pin is no edge
  assign act      = lvl_i ^ pol_i;
  assign act_prev = prev_q ^ pol_i;
  assign hit_o    = (edge_mode_i & act & ~act_prev) | (~edge_mode_i & act);
endmodule

// File: rtl/pin_irq_chan.sv
module pin_irq_chan
  import pin_irq_pkg::*;
#(
  parameter int NUM_HP      = 8,
  parameter int SLOTS       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_HP*8-1:0]   pins_i,
  input  logic                  reg_we_i,
  input  logic [REG_AW-1:0]     reg_addr_i,
  input  logic [REG_DW-1:0]     reg_wdata_i,
  output logic [REG_DW-1:0]     reg_rdata_o,
  output logic                  irq_o
);
  localparam int NPIN  = NUM_HP * 8;
  localparam int CH_W  = SLOTS * 8;
  localparam int SEL_W = (NUM_HP > 1) ? $clog2(NUM_HP) : 1;

  logic [NPIN-1:0]        pins_s;
  logic [SLOTS*SEL_W-1:0] sel_q;
  logic [CH_W-1:0]        routed, hit, trig_q, pol_q, mask_q, latch_q;
  logic [CH_W-1:0]        wbits, lat_set, lat_clr;
  logic [REG_DW-1:0]      rd_route;

  pin_irq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pins_i), .q_o(pins_s)
  );

  pin_irq_route #(.NUM_HP(NUM_HP), .SLOTS(SLOTS), .SEL_W(SEL_W)) u_route (
    .pins_i(pins_s), .sel_i(sel_q), .ch_o(routed)
  );

  pin_irq_detect #(.W(CH_W)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(routed),
    .edge_mode_i(trig_q), .pol_i(pol_q), .hit_o(hit)
  );

  assign wbits   = reg_wdata_i[CH_W-1:0];
  assign lat_set = (reg_we_i && reg_addr_i == ADR_LAT_SET) ? wbits : '0;
  assign lat_clr = (reg_we_i && reg_addr_i == ADR_LAT_CLR) ? wbits : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      trig_q  <= '0;
      pol_q   <= '0;
      mask_q  <= '0;
      latch_q <= '0;
    end else begin
      if (reg_we_i) begin
        unique case (reg_addr_i)
          ADR_ROUTE: begin
            for (int k = 0; k < SLOTS; k++) sel_q[k*SEL_W +: SEL_W] <= reg_wdata_i[k*8 +: SEL_W];
          end
          ADR_TRIG:     trig_q <= wbits;
          ADR_POL:      pol_q  <= wbits;
          ADR_MASK_SET: mask_q <= mask_q | wbits;
          ADR_MASK_CLR: mask_q <= mask_q & ~wbits;
          default: ;
        endcase
      end
      // a hit in the same cycle overrides a clear
      latch_q <= (latch_q & ~lat_clr) | lat_set | hit;
    end
  end

  always_comb begin
    rd_route = '0;
    for (int k = 0; k < SLOTS; k++) rd_route[k*8 +: SEL_W] = sel_q[k*SEL_W +: SEL_W];
  end

  always_comb begin
    case (reg_addr_i)
      ADR_ROUTE:                reg_rdata_o = rd_route;
      ADR_TRIG:                 reg_rdata_o = REG_DW'(trig_q);
      ADR_POL:                  reg_rdata_o = REG_DW'(pol_q);
      ADR_MASK_SET, ADR_MASK_CLR: reg_rdata_o = REG_DW'(mask_q);
      ADR_LAT_SET, ADR_LAT_CLR:   reg_rdata_o = REG_DW'(latch_q);
      ADR_PIN:                  reg_rdata_o = REG_DW'(routed);
      default:                  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(latch_q & mask_q);
endmodule

// File: rtl/pin_irq_chan_chk.sv
module pin_irq_chan_chk
  import pin_irq_pkg::*;
#(
  parameter int CH_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [REG_DW-1:0] reg_wdata_i,
  input logic              irq_o,
  input logic [CH_W-1:0]   mask_i,
  input logic [CH_W-1:0]   latch_i,
  input logic [CH_W-1:0]   routed_i,
  input logic [CH_W-1:0]   trig_i,
  input logic [CH_W-1:0]   pol_i
);
  logic [CH_W-1:0] lvl_act;
  assign lvl_act = ~trig_i & (routed_i ^ pol_i);

  a_r7_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADR_MASK_SET) |=>
      ((mask_i & $past(reg_wdata_i[CH_W-1:0])) == $past(reg_wdata_i[CH_W-1:0])));

  a_r7_mask_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADR_MASK_CLR) |=>
      ((mask_i & $past(reg_wdata_i[CH_W-1:0])) == '0));

  a_r5_level_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_act != '0) |=> ((latch_i & $past(lvl_act)) == $past(lvl_act)));

  a_r8_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !irq_o);

  a_r8_unmasked_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((latch_i & mask_i) != '0) |-> irq_o);
endmodule

bind pin_irq_chan pin_irq_chan_chk #(.CH_W(SLOTS*8)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .irq_o(irq_o), .mask_i(mask_q), .latch_i(latch_q),
  .routed_i(routed), .trig_i(trig_q), .pol_i(pol_q)
);

// File: tb/pin_irq_chan_tb.sv
module pin_irq_chan_tb;
  localparam int NHP = 8;
  localparam int NP  = NHP * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          we = 1'b0;
  logic [3:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pin_irq_chan u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  logic [NP-1:0] m_s1, m_s2;
  logic [31:0]   m_prev, m_trig, m_pol, m_mask, m_lat;
  int            m_sel [4];

  function automatic logic [31:0] m_route(logic [NP-1:0] p);
    logic [31:0] r;
    for (int k = 0; k < 4; k++)
      for (int j = 0; j < 8; j++) r[k*8+j] = p[m_sel[k]*8+j];
    return r;
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      4'd0: for (int k = 0; k < 4; k++) r[k*8 +: 8] = 8'(m_sel[k]);
      4'd1: r = m_trig;
      4'd2: r = m_pol;
      4'd3, 4'd4: r = m_mask;
      4'd5, 4'd6: r = m_lat;
      4'd7: r = m_route(m_s2);
      default: r = '0;
    endcase
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_trig = '0; m_pol = '0;
      m_mask = '0; m_lat = '0;
      for (int k = 0; k < 4; k++) m_sel[k] = 0;
    end else begin
      logic [31:0] cur, act, actp, hit, nlat;
      cur  = m_route(m_s2);
      act  = cur ^ m_pol;
      actp = m_prev ^ m_pol;
      hit  = 32'b0;
      for (int b = 0; b < 32; b++)
        hit[b] = m_trig[b] ? (act[b] && !actp[b]) : act[b];
      nlat = m_lat;
      if (we && addr == 4'd6) nlat = nlat & ~wdata;
      if (we && addr == 4'd5) nlat = nlat | wdata;
      nlat = nlat | hit;
      if (we) begin
        case (addr)
          4'd0: for (int k = 0; k < 4; k++) m_sel[k] = int'(wdata[k*8 +: 3]);
          4'd1: m_trig = wdata;
          4'd2: m_pol = wdata;
          4'd3: m_mask = m_mask | wdata;
          4'd4: m_mask = m_mask & ~wdata;
          default: ;
        endcase
      end
      m_lat  = nlat;
      m_prev = cur;
      m_s2   = m_s1;
      m_s1   = pins;
    end
  end

  // compare request line every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq !== |(m_lat & m_mask)) begin
        errors++;
        $display("FAIL R8 irq_o actual=%0b expected=%0b t=%0t", irq, |(m_lat & m_mask), $time);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    logic [31:0] e;
    addr = a;
    #1;
    e = m_read(a);
    checks++;
    if (rdata !== e) begin
      errors++;
      $display("FAIL %s word %0d actual=%h expected=%h", tag, a, rdata, e);
    end
  endtask

  task automatic rd_exp(input logic [3:0] a, input logic [31:0] e, input string tag);
    addr = a;
    #1;
    checks++;
    if (rdata !== e) begin
      errors++;
      $display("FAIL %s word %0d actual=%h expected=%h", tag, a, rdata, e);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1: reset values
    for (int a = 0; a < 8; a++) rd_exp(4'(a), 32'h0, "R1");
    checks++;
    if (irq !== 1'b0) begin errors++; $display("FAIL R1 irq actual=%0b expected=0", irq); end

    // R2 routing: slot0<-hp3, slot1<-hp0, slot2<-hp7, slot3<-hp5
    wr(4'd0, 32'h05_07_00_03);
    rd_exp(4'd0, 32'h05_07_00_03, "R2");
    @(negedge clk);
    pins = '0;
    pins[3*8 +: 8] = 8'hA5; pins[0 +: 8] = 8'h3C; pins[7*8 +: 8] = 8'hF0; pins[5*8 +: 8] = 8'h81;
    pins[1*8 +: 8] = 8'hFF;
    // R9: visible after second rising edge
    @(posedge clk); #1; rd_exp(4'd7, 32'h0, "R9");
    @(posedge clk); #1; rd_exp(4'd7, 32'h81_F0_3C_A5, "R9");
    rd(4'd7, "R2");
    // R3: polarity and mask leave pin state alone
    wr(4'd2, 32'hFFFF_FFFF);
    wr(4'd3, 32'hFFFF_FFFF);
    rd_exp(4'd7, 32'h81_F0_3C_A5, "R3");
    wr(4'd2, 32'h0);
    wr(4'd4, 32'hFFFF_FFFF);
    wr(4'd6, 32'hFFFF_FFFF);
    cyc(1);

    // R4 edge mode, rising
    wr(4'd1, 32'hFFFF_FFFF);
    @(negedge clk); pins = '0;
    cyc(4);
    wr(4'd6, 32'hFFFF_FFFF);
    rd_exp(4'd5, 32'h0, "R4");
    @(negedge clk); pins[3*8 +: 8] = 8'h0F;
    @(posedge clk); @(posedge clk); #1; rd_exp(4'd5, 32'h0, "R9");
    @(posedge clk); #1; rd_exp(4'd5, 32'h0000_000F, "R9");
    rd(4'd6, "R4");
    wr(4'd6, 32'hFFFF_FFFF);
    // falling with pol=0 does nothing
    @(negedge clk); pins[3*8 +: 8] = 8'h00;
    cyc(4);
    rd_exp(4'd5, 32'h0, "R4");
    // falling edge with pol=1 on slot0
    wr(4'd2, 32'h0000_00FF);
    cyc(3);
    rd_exp(4'd5, 32'h0, "R4");
    @(negedge clk); pins[3*8 +: 8] = 8'hFF;
    cyc(4);
    @(negedge clk); pins[3*8 +: 8] = 8'h00;
    cyc(4);
    rd_exp(4'd5, 32'h0000_00FF, "R4");

    // R6: masked latch capture, R8 irq follows mask
    wr(4'd3, 32'h0000_0001);
    rd_exp(4'd3, 32'h0000_0001, "R7");
    checks++;
    if (irq !== 1'b1) begin errors++; $display("FAIL R8 irq actual=%0b expected=1", irq); end
    wr(4'd4, 32'h0000_0001);
    checks++;
    if (irq !== 1'b0) begin errors++; $display("FAIL R8 irq actual=%0b expected=0", irq); end
    rd_exp(4'd6, 32'h0000_00FF, "R6");

    // R7 partial set/clear
    wr(4'd6, 32'h0000_000F);
    rd_exp(4'd5, 32'h0000_00F0, "R7");
    wr(4'd5, 32'h1200_0000);
    rd_exp(4'd6, 32'h1200_00F0, "R7");
    wr(4'd3, 32'h00F0_0F00);
    wr(4'd4, 32'h0000_0300);
    rd_exp(4'd4, 32'h00F0_0C00, "R7");
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd4, 32'hFFFF_FFFF);

    // R5 level mode: clear while active has no effect
    wr(4'd2, 32'h0);
    wr(4'd1, 32'h0);
    @(negedge clk); pins[0 +: 8] = 8'h01;
    cyc(4);
    wr(4'd6, 32'h0000_0100);
    rd_exp(4'd5, 32'h0000_0100, "R5");
    wr(4'd3, 32'h0000_0100);
    @(negedge clk); pins[0 +: 8] = 8'h00;
    cyc(4);
    rd_exp(4'd5, 32'h0000_0100, "R5");
    wr(4'd6, 32'h0000_0100);
    rd_exp(4'd5, 32'h0000_0000, "R5");
    // active-low level on slot2
    wr(4'd2, 32'h0001_0000);
    cyc(2);
    rd(4'd5, "R5");
    wr(4'd2, 32'h0);
    wr(4'd6, 32'hFFFF_FFFF);

    // R10: unmapped words
    wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd15, 32'hFFFF_FFFF);
    rd_exp(4'd9, 32'h0, "R10");
    rd_exp(4'd12, 32'h0, "R10");
    for (int a = 0; a < 8; a++) rd(4'(a), "R10");

    // mixed random traffic against the model
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      pins = {$urandom, $urandom};
      if (i % 7 == 0) wr(4'($urandom_range(0, 7)), $urandom);
      if (i % 5 == 0) rd(4'($urandom_range(0, 15)), "R4");
    end
    cyc(4);
    for (int a = 0; a < 8; a++) rd(4'(a), "R6");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule